// File: doc/BRIEF.md
# Dual Byte FIFO with DMA-Aware Ready Pins

This block holds two byte queues for a serial peripheral. The receive queue is filled from the line side and drained by the host. The transmit queue is filled by the host and drained by the line side. Each queue drives an active-low ready pin that a host or DMA engine watches.

When DMA signalling is off, each pin simply follows whether its queue is empty. When DMA signalling is on, each pin changes state at one threshold and changes back at a different one. Between those two thresholds it keeps its state, so a DMA engine can move data in blocks instead of byte by byte.

A 2-bit select picks one trigger level, and that level applies to both directions. A one-cycle time-out pulse from outside can also flag the receive side as ready. Serial shifting, the time-out timer and the register file sit elsewhere.

Top module: `dual_fifo_ready`

## Requirements
- R1: Each queue holds up to DEPTH bytes (default 32) and returns them in push order. The oldest byte is shown on its data output while the queue is not empty.
- R2: A push into a full queue, or a pop from an empty queue, leaves the queue unchanged and raises that queue's error output for exactly the next cycle. When a push and a pop arrive in the same cycle, each is judged against the fill before the edge.
- R3: With dma_mode low, rx_ready_n is 1 exactly when the receive queue is empty and 0 when it holds one or more bytes.
- R4: With dma_mode low, tx_ready_n is 1 when the transmit queue holds one or more bytes and 0 when it is empty.
- R5: The trigger level is set by trig_sel: 0 gives 1 byte, 1 gives 8, 2 gives 16 and 3 gives 28. Both directions use the same level.
- R6: With dma_mode high, rx_ready_n goes to 1 whenever the receive queue is empty. Otherwise it goes to 0 when the fill reaches the trigger level or when rx_timeout is high. In all other cases it holds its value. A time-out while the queue is empty leaves the pin at 1.
- R7: With dma_mode high, tx_ready_n goes to 1 when the transmit queue is full and to 0 when the fill is below the trigger level. Between the two it holds its value.
- R8: After reset both queues are empty, rx_ready_n is 1, tx_ready_n is 0 and both error outputs are 0.
- R9: Each pin updates on the same clock edge as the fill change that moves it. The update uses the dma_mode and trig_sel values sampled at that edge, so a mode change is applied to the current fill at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | 1 selects DMA block signalling |
| trig_sel | input | 2 | Trigger level select |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| rx_push | input | 1 | Line-side write into receive queue |
| rx_din | input | 8 | Receive byte in |
| rx_pop | input | 1 | Host read from receive queue |
| rx_dout | output | 8 | Oldest receive byte |
| rx_err | output | 1 | Receive overflow/underflow, one cycle |
| tx_push | input | 1 | Host write into transmit queue |
| tx_din | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Line-side read from transmit queue |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_err | output | 1 | Transmit overflow/underflow, one cycle |
| rx_ready_n | output | 1 | Active-low receive ready |
| tx_ready_n | output | 1 | Active-low transmit ready |

## Verification
The bench goes after the hold region in DMA mode. A design that follows the fill level there would make rx_ready_n fall after one byte instead of at the trigger, and would make tx_ready_n fall as soon as one byte is popped from a full queue. It also drives a time-out pulse while the receive queue is empty, which a design that gives the time-out priority over the empty rule would get wrong. It drives pushes into a full queue and pops from an empty one, which a design that wraps its pointers would turn into corrupted data and a wrong fill. It also switches the mode while the fill is between the thresholds, where a design that lags one edge or forgets the held state would show a stale pin.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'd0,
      TRIG_SEL_B = 2'd1,
      TRIG_SEL_C = 2'd2,
      TRIG_SEL_D = 2'd3
   } trig_sel_e;

   function automatic int pick_level(input trig_sel_e sel, input int l0, input int l1,
                                     input int l2, input int l3);
      case (sel)
         TRIG_SEL_A: return l0;
         TRIG_SEL_B: return l1;
         TRIG_SEL_C: return l2;
         default:    return l3;
      endcase
   endfunction
endpackage

// File: rtl/dfr_byte_fifo.sv
module dfr_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt,
   output logic          err
);
   initial begin : p_param_chk
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("dfr_byte_fifo: DEPTH must be a power of two >= 2");
      assert (W >= 1) else $error("dfr_byte_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, empty, wr_ok, rd_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign wr_ok   = push && !full;
   assign rd_ok   = pop && !empty;
   assign cnt_nxt = cnt_q + CW'(wr_ok) - CW'(rd_ok);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         err    <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         cnt_q <= cnt_nxt;
         err   <= (push && full) || (pop && empty);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R1
   AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (err && $stable(wr_ptr))); // R2
   AST_EMPTY_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> (err && $stable(rd_ptr))); // R2
endmodule

// File: rtl/dfr_ready_ctrl.sv
module dfr_ready_ctrl #(
   parameter int DEPTH = 32,
   parameter bit IS_RX = 1'b1,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dma,
   input  logic [CW-1:0] trig,
   input  logic [CW-1:0] cnt_nxt,
   input  logic          timeout,
   output logic          pin_n
);
   generate
      if (IS_RX) begin : g_rx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pin_n <= 1'b1;
            else if (!dma)                       pin_n <= (cnt_nxt == '0);
            else if (cnt_nxt == '0)              pin_n <= 1'b1;
            else if (cnt_nxt >= trig || timeout) pin_n <= 1'b0;
         end
      end else begin : g_tx
         wire unused_timeout = timeout;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        pin_n <= 1'b0;
            else if (!dma)                     pin_n <= (cnt_nxt != '0);
            else if (cnt_nxt == CW'(DEPTH))    pin_n <= 1'b1;
            else if (cnt_nxt < trig)           pin_n <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/dual_fifo_ready.sv
module dual_fifo_ready #(
   parameter int W       = 8,
   parameter int DEPTH   = 32,
   parameter int TRIG_L0 = 1,
   parameter int TRIG_L1 = 8,
   parameter int TRIG_L2 = 16,
   parameter int TRIG_L3 = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dma_mode,
   input  logic [1:0]   trig_sel,
   input  logic         rx_timeout,
   input  logic         rx_push,
   input  logic [W-1:0] rx_din,
   input  logic         rx_pop,
   output logic [W-1:0] rx_dout,
   output logic         rx_err,
   input  logic         tx_push,
   input  logic [W-1:0] tx_din,
   input  logic         tx_pop,
   output logic [W-1:0] tx_dout,
   output logic         tx_err,
   output logic         rx_ready_n,
   output logic         tx_ready_n
);
   localparam int CW = $clog2(DEPTH) + 1;

   initial begin : p_trig_chk
      assert (TRIG_L0 >= 1 && TRIG_L0 <= DEPTH) else $error("TRIG_L0 out of range");
      assert (TRIG_L1 >= 1 && TRIG_L1 <= DEPTH) else $error("TRIG_L1 out of range");
      assert (TRIG_L2 >= 1 && TRIG_L2 <= DEPTH) else $error("TRIG_L2 out of range");
      assert (TRIG_L3 >= 1 && TRIG_L3 <= DEPTH) else $error("TRIG_L3 out of range");
   end

   logic [CW-1:0] trig;
   logic [CW-1:0] rx_cnt, rx_cnt_nxt, tx_cnt, tx_cnt_nxt;

   assign trig = CW'(dfr_pkg::pick_level(dfr_pkg::trig_sel_e'(trig_sel),
                                         TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3));

   dfr_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_dout), .cnt_q(rx_cnt), .cnt_nxt(rx_cnt_nxt), .err(rx_err));

   dfr_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din), .pop(tx_pop),
      .dout(tx_dout), .cnt_q(tx_cnt), .cnt_nxt(tx_cnt_nxt), .err(tx_err));

   dfr_ready_ctrl #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_rdy (
      .clk(clk), .rst_n(rst_n), .dma(dma_mode), .trig(trig),
      .cnt_nxt(rx_cnt_nxt), .timeout(rx_timeout), .pin_n(rx_ready_n));

   dfr_ready_ctrl #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_rdy (
      .clk(clk), .rst_n(rst_n), .dma(dma_mode), .trig(trig),
      .cnt_nxt(tx_cnt_nxt), .timeout(1'b0), .pin_n(tx_ready_n));

   AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0) |-> rx_ready_n); // R3
   AST_TX_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == '0) |-> !tx_ready_n); // R4
   AST_TX_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH)) |-> tx_ready_n); // R7
   AST_RX_TIMEOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_mode && rx_timeout && !rx_pop && rx_cnt != '0) |=> !rx_ready_n); // R6
   AST_RX_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_mode |=> (rx_ready_n == (rx_cnt == '0))); // R9
endmodule

// File: tb/dual_fifo_ready_bench.sv
module dual_fifo_ready_bench;
   localparam int DEPTH = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dma_mode = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       rx_timeout = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic       tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0] rx_din = '0, tx_din = '0;
   logic [7:0] rx_dout, tx_dout;
   logic       rx_err, tx_err, rx_ready_n, tx_ready_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   byte unsigned rx_q[$];
   byte unsigned tx_q[$];
   bit m_rx_pin = 1'b1, m_tx_pin = 1'b0, m_rx_err = 1'b0, m_tx_err = 1'b0;

   always #4 clk = ~clk;

   dual_fifo_ready u_dual_fifo_ready (
      .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .trig_sel(trig_sel),
      .rx_timeout(rx_timeout), .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop),
      .rx_dout(rx_dout), .rx_err(rx_err), .tx_push(tx_push), .tx_din(tx_din),
      .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_err(tx_err),
      .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n));

   function automatic int level_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 8;
         2'd2: return 16;
         default: return 28;
      endcase
   endfunction

   function automatic bit next_rx_pin(input bit dma, input int n, input int trig,
                                      input bit to, input bit prev);
      if (!dma) return n == 0;
      if (n == 0) return 1'b1;
      if (n >= trig || to) return 1'b0;
      return prev;
   endfunction

   function automatic bit next_tx_pin(input bit dma, input int n, input int trig,
                                      input bit prev);
      if (!dma) return n != 0;
      if (n == DEPTH) return 1'b1;
      if (n < trig) return 1'b0;
      return prev;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit rpu, input bit rpo, input bit tpu, input bit tpo,
                       input bit to, input bit dma, input logic [1:0] ts);
      bit r_wr, r_rd, t_wr, t_rd;
      int trig;
      rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
      rx_timeout = to; dma_mode = dma; trig_sel = ts;
      rx_din = 8'($urandom); tx_din = 8'($urandom);
      @(posedge clk);
      trig = level_of(ts);
      r_wr = rpu && rx_q.size() < DEPTH;
      r_rd = rpo && rx_q.size() > 0;
      t_wr = tpu && tx_q.size() < DEPTH;
      t_rd = tpo && tx_q.size() > 0;
      m_rx_err = (rpu && !r_wr) || (rpo && !r_rd);
      m_tx_err = (tpu && !t_wr) || (tpo && !t_rd);
      if (r_rd) void'(rx_q.pop_front());
      if (r_wr) rx_q.push_back(rx_din);
      if (t_rd) void'(tx_q.pop_front());
      if (t_wr) tx_q.push_back(tx_din);
      m_rx_pin = next_rx_pin(dma, rx_q.size(), trig, to, m_rx_pin);
      m_tx_pin = next_tx_pin(dma, tx_q.size(), trig, m_tx_pin);
      @(negedge clk);
      rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_timeout = 0;
      check(dma ? "R6 rx_ready_n" : "R3 rx_ready_n", rx_ready_n, m_rx_pin);
      check(dma ? "R7 tx_ready_n" : "R4 tx_ready_n", tx_ready_n, m_tx_pin);
      check("R2 rx_err", rx_err, m_rx_err);
      check("R2 tx_err", tx_err, m_tx_err);
      if (rx_q.size() > 0) check("R1 rx_dout", rx_dout, rx_q[0]);
      if (tx_q.size() > 0) check("R1 tx_dout", tx_dout, tx_q[0]);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 rx_ready_n reset", rx_ready_n, 1);
      check("R8 tx_ready_n reset", tx_ready_n, 0);
      check("R8 rx_err reset", rx_err, 0);
      check("R8 tx_err reset", tx_err, 0);

      // R3/R4 non-DMA level following
      step(1, 0, 1, 0, 0, 0, 2'd1);
      check("R3 one byte ready", rx_ready_n, 0);
      check("R4 one byte held", tx_ready_n, 1);
      step(0, 1, 0, 1, 0, 0, 2'd1);
      check("R3 empty again", rx_ready_n, 1);

      // R5 trigger 8, DMA hold region on receive
      for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 1, 2'd1);
      check("R5 rx below trigger 8 held", rx_ready_n, 1);
      step(1, 0, 0, 0, 0, 1, 2'd1);
      check("R5 rx at trigger 8", rx_ready_n, 0);
      for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 0, 1, 2'd1);
      check("R6 rx held until empty", rx_ready_n, 0);
      step(0, 1, 0, 0, 0, 1, 2'd1);
      check("R6 rx empty releases", rx_ready_n, 1);

      // R6 time-out, empty and non-empty
      step(0, 0, 0, 0, 1, 1, 2'd3);
      check("R6 timeout on empty", rx_ready_n, 1);
      step(1, 0, 0, 0, 0, 1, 2'd3);
      step(1, 0, 0, 0, 0, 1, 2'd3);
      check("R6 two bytes under trig 28", rx_ready_n, 1);
      step(0, 0, 0, 0, 1, 1, 2'd3);
      check("R6 timeout asserts", rx_ready_n, 0);

      // R9 mode switch while in hold region: DMA rx pin 0 with 2 bytes, tx
      step(0, 1, 0, 0, 0, 1, 2'd3);
      step(0, 0, 0, 0, 0, 0, 2'd3);
      check("R9 switch off recompute rx", rx_ready_n, 0);
      step(0, 1, 0, 0, 0, 0, 2'd3);

      // R7 transmit DMA hysteresis, trigger 28
      for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 1, 0, 0, 1, 2'd3);
      check("R7 tx 31 bytes not yet full", tx_ready_n, 0);
      step(0, 0, 1, 0, 0, 1, 2'd3);
      check("R7 tx full", tx_ready_n, 1);
      step(0, 0, 1, 0, 0, 1, 2'd3);
      check("R2 overflow flag", tx_err, 1);
      check("R1 overflow keeps full", tx_ready_n, 1);
      step(0, 0, 0, 0, 0, 1, 2'd3);
      check("R2 flag lasts one cycle", tx_err, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 1, 2'd3);
      check("R7 tx at 28 held", tx_ready_n, 1);
      step(0, 0, 0, 1, 0, 1, 2'd3);
      check("R7 tx below 28 releases", tx_ready_n, 0);
      step(0, 0, 0, 0, 0, 0, 2'd3);
      check("R9 switch off tx follows", tx_ready_n, 1);
      for (int i = 0; i < 27; i++) step(0, 0, 0, 1, 0, 0, 2'd3);
      step(0, 0, 0, 1, 0, 0, 2'd3);
      check("R2 underflow flag", tx_err, 1);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int bias = (i / 500) % 2;
         step($urandom_range(99) < (bias ? 70 : 35), $urandom_range(99) < (bias ? 35 : 70),
              $urandom_range(99) < (bias ? 70 : 35), $urandom_range(99) < (bias ? 35 : 70),
              $urandom_range(99) < 5, (i / 250) % 3 != 0, 2'($urandom_range(3)));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule